// File: doc/BRIEF.md
# Logic Analyzer Command Receiver

This block sits between a host byte link and the capture engine of a logic analyzer. It takes the raw byte stream from the host, splits it into commands, and holds the capture configuration these commands write. A command is either a single opcode byte or an opcode byte followed by a 32-bit argument in four bytes. Bit 7 of the opcode tells the two apart.

Long commands load the sample-clock divider, the read and delay counts, the flag word, and four 32-bit words (mask, value, config, edge) for each trigger stage. Short commands arm the capture engine, abort it, or ask for a reply. Replies are either a four-byte identity string or a descriptor built from tagged fields. Replies leave on a byte stream with valid/ready handshaking. The framing recovers from a lost position: five zero bytes in a row always leave the parser idle, whatever it was doing before.

Top module: `la_cmd_rx`

## Requirements
- R1: After reset, every configuration output is zero, `tx_valid_o`, `run_o`, `abort_o` and `armed_o` are low, and the parser expects an opcode.
- R2: An opcode with bit 7 clear is a one-byte command. An opcode with bit 7 set is followed by four argument bytes. Short opcodes other than 0x00, 0x01, 0x02 and 0x04 are consumed with no effect. Long opcodes 0x84..0xBF and trigger opcodes for stages at or above `NUM_STAGES` are also consumed with no effect: no register changes, no reply and no strobe.
- R3: Argument bytes arrive least significant first. Opcode 0x81 loads all 32 bits into `read_cnt_o`, and opcode 0x82 loads all 32 bits into `delay_cnt_o`.
- R4: Opcode 0x80 loads argument bits 23:0 into `divider_o` and ignores the fourth byte. Opcode 0x83 loads argument bits 15:0 into `flags_o` and ignores the upper two bytes.
- R5: A trigger opcode is 0xC0 + 4*stage + kind, where kind 0 is mask, 1 is value, 2 is config and 3 is edge. It loads the 32-bit argument into bits [32*stage +: 32] of the matching trigger output.
- R6: Opcode 0x02 sends the bytes 0x31, 0x53, 0x4C, 0x4F in that order. A byte offered while `tx_ready_i` is low stays on `tx_data_o` unchanged.
- R7: Opcode 0x04 sends a 22-byte descriptor, in this order:
  - tag 0x01, then the text "LACMD", then 0x00;
  - tag 0x21, then `MEM_BYTES` as four bytes, most significant first;
  - tag 0x23, then `MAX_RATE_HZ` as four bytes, most significant first;
  - tag 0x40, then `NUM_PROBES` as one byte;
  - tag 0x41, then `PROTO_VER` as one byte;
  - a closing 0x00.
- R8: Opcode 0x01 pulses `run_o` for one cycle and sets `armed_o`. `armed_o` clears on `done_i` or on a reset command. `run_o` and `abort_o` are never high together.
- R9: Opcode 0x00 pulses `abort_o` for one cycle, clears `armed_o`, and drops any reply in progress. No further reply bytes are offered.
- R10: From any position inside a long command, five 0x00 bytes leave the parser idle. A command that starts partway through the zeros is completed by them. The zeros that remain each act as a reset command, so `abort_o` pulses once per leftover zero. The next opcode is then decoded correctly.
- R11: A query opcode (0x02 or 0x04) received while a reply is still being sent is dropped. The reply in progress finishes unchanged.
- R12: Registers, strobes and the start of a reply change only in response to host bytes. Each takes effect exactly two clock edges after the edge that accepts the final byte of its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Host byte |
| rx_valid_i | input | 1 | Host byte present this cycle |
| tx_data_o | output | 8 | Reply byte |
| tx_valid_o | output | 1 | Reply byte offered |
| tx_ready_i | input | 1 | Host takes the offered byte |
| done_i | input | 1 | Capture engine finished |
| run_o | output | 1 | One-cycle arm strobe |
| abort_o | output | 1 | One-cycle abort strobe |
| armed_o | output | 1 | Capture armed and not yet finished |
| divider_o | output | DIV_W | Sample-clock divider |
| read_cnt_o | output | CNT_W | Read count |
| delay_cnt_o | output | CNT_W | Delay count |
| flags_o | output | FLAG_W | Flag word |
| trig_mask_o | output | NUM_STAGES*32 | Trigger mask words, stage 0 lowest |
| trig_value_o | output | NUM_STAGES*32 | Trigger value words |
| trig_cfg_o | output | NUM_STAGES*32 | Trigger config words |
| trig_edge_o | output | NUM_STAGES*32 | Trigger edge words |

## Verification
The parser is driven with random argument values for every register opcode, with random gaps between bytes, and with a random mix of commands checked against a bench model. This separates correct byte ordering and field truncation from shifted or stale loads.

Directed streams cover three corner areas:
- undefined opcodes of both lengths, to show that a consumed command leaves no trace and does not break alignment;
- partial long commands of every length followed by five zeros, where the count of abort pulses shows exactly where the parser resynchronised;
- replies under a random, stalled and aborted ready, together with queries that overlap a reply, to show that handshaking and cancellation behave correctly.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_ID    = 8'h02;
  localparam logic [7:0] OP_META  = 8'h04;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_RCNT  = 8'h81;
  localparam logic [7:0] OP_DCNT  = 8'h82;
  localparam logic [7:0] OP_FLAGS = 8'h83;
  localparam logic [1:0] TRIG_SEL = 2'b11;
  localparam int unsigned WORD_W  = 32;

  typedef enum logic [1:0] {
    K_MASK = 2'd0,
    K_VAL  = 2'd1,
    K_CFG  = 2'd2,
    K_EDGE = 2'd3
  } trig_kind_e;

  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_ID   = 2'd1,
    RSP_META = 2'd2
  } rsp_state_e;
endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic        cmd_vld_o,
  output logic [7:0]  cmd_op_o,
  output logic [31:0] cmd_arg_o
);
  logic [2:0]  pos_q;
  logic [7:0]  op_q;
  logic [23:0] arg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      op_q      <= '0;
      arg_q     <= '0;
      cmd_vld_o <= 1'b0;
      cmd_op_o  <= '0;
      cmd_arg_o <= '0;
    end else begin
      cmd_vld_o <= 1'b0;
      if (rx_valid_i) begin
        case (pos_q)
          3'd0: begin
            if (rx_data_i[7]) begin
              op_q  <= rx_data_i;
              arg_q <= '0;
              pos_q <= 3'd1;
            end else begin
              cmd_vld_o <= 1'b1;
              cmd_op_o  <= rx_data_i;
              cmd_arg_o <= '0;
            end
          end
          3'd1: begin arg_q[7:0]   <= rx_data_i; pos_q <= 3'd2; end
          3'd2: begin arg_q[15:8]  <= rx_data_i; pos_q <= 3'd3; end
          3'd3: begin arg_q[23:16] <= rx_data_i; pos_q <= 3'd4; end
          default: begin
            cmd_vld_o <= 1'b1;
            cmd_op_o  <= op_q;
            cmd_arg_o <= {rx_data_i, arg_q};
            pos_q     <= 3'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/la_cmd_regs.sv
module la_cmd_regs
  import la_cmd_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned DIV_W      = 24,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned FLAG_W     = 16,
  localparam int unsigned TRIG_W    = NUM_STAGES * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [31:0]       cmd_arg_i,
  input  logic              done_i,
  output logic              id_req_o,
  output logic              meta_req_o,
  output logic              flush_o,
  output logic              run_o,
  output logic              abort_o,
  output logic              armed_o,
  output logic [DIV_W-1:0]  divider_o,
  output logic [CNT_W-1:0]  read_cnt_o,
  output logic [CNT_W-1:0]  delay_cnt_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [TRIG_W-1:0] trig_mask_o,
  output logic [TRIG_W-1:0] trig_value_o,
  output logic [TRIG_W-1:0] trig_cfg_o,
  output logic [TRIG_W-1:0] trig_edge_o
);
  logic is_run, is_rst;
  logic trig_sel;

  assign is_run     = cmd_vld_i && (cmd_op_i == OP_RUN);
  assign is_rst     = cmd_vld_i && (cmd_op_i == OP_RESET);
  assign id_req_o   = cmd_vld_i && (cmd_op_i == OP_ID);
  assign meta_req_o = cmd_vld_i && (cmd_op_i == OP_META);
  assign flush_o    = is_rst;
  assign trig_sel   = cmd_vld_i && (cmd_op_i[7:6] == TRIG_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      abort_o <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      run_o   <= is_run;
      abort_o <= is_rst;
      if (is_run)               armed_o <= 1'b1;
      else if (is_rst || done_i) armed_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      divider_o   <= '0;
      read_cnt_o  <= '0;
      delay_cnt_o <= '0;
      flags_o     <= '0;
    end else if (cmd_vld_i) begin
      case (cmd_op_i)
        OP_DIV:   divider_o   <= cmd_arg_i[DIV_W-1:0];
        OP_RCNT:  read_cnt_o  <= cmd_arg_i[CNT_W-1:0];
        OP_DCNT:  delay_cnt_o <= cmd_arg_i[CNT_W-1:0];
        OP_FLAGS: flags_o     <= cmd_arg_i[FLAG_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic              hit;
    logic [WORD_W-1:0] mask_q, val_q, cfg_q, edge_q;

    assign hit = trig_sel && (cmd_op_i[5:2] == 4'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
        val_q  <= '0;
        cfg_q  <= '0;
        edge_q <= '0;
      end else if (hit) begin
        case (trig_kind_e'(cmd_op_i[1:0]))
          K_MASK: mask_q <= cmd_arg_i;
          K_VAL:  val_q  <= cmd_arg_i;
          K_CFG:  cfg_q  <= cmd_arg_i;
          default: edge_q <= cmd_arg_i;
        endcase
      end
    end

    assign trig_mask_o[s*WORD_W +: WORD_W]  = mask_q;
    assign trig_value_o[s*WORD_W +: WORD_W] = val_q;
    assign trig_cfg_o[s*WORD_W +: WORD_W]   = cfg_q;
    assign trig_edge_o[s*WORD_W +: WORD_W]  = edge_q;
  end
endmodule

// File: rtl/la_cmd_resp.sv
module la_cmd_resp
  import la_cmd_pkg::*;
#(
  parameter logic [31:0] MEM_BYTES   = 32'h0000_6000,
  parameter logic [31:0] MAX_RATE_HZ = 32'd100_000_000,
  parameter logic [7:0]  NUM_PROBES  = 8'd32,
  parameter logic [7:0]  PROTO_VER   = 8'd2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       id_req_i,
  input  logic       meta_req_i,
  input  logic       flush_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i
);
  localparam int unsigned META_LEN = 22;
  localparam int unsigned ID_LEN   = 4;
  localparam int unsigned IDX_W    = $clog2(META_LEN);

  rsp_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             last;

  function automatic logic [7:0] meta_byte(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:  return 8'h01;
      5'd1:  return "L";
      5'd2:  return "A";
      5'd3:  return "C";
      5'd4:  return "M";
      5'd5:  return "D";
      5'd6:  return 8'h00;
      5'd7:  return 8'h21;
      5'd8:  return MEM_BYTES[31:24];
      5'd9:  return MEM_BYTES[23:16];
      5'd10: return MEM_BYTES[15:8];
      5'd11: return MEM_BYTES[7:0];
      5'd12: return 8'h23;
      5'd13: return MAX_RATE_HZ[31:24];
      5'd14: return MAX_RATE_HZ[23:16];
      5'd15: return MAX_RATE_HZ[15:8];
      5'd16: return MAX_RATE_HZ[7:0];
      5'd17: return 8'h40;
      5'd18: return NUM_PROBES;
      5'd19: return 8'h41;
      5'd20: return PROTO_VER;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:    return "1";
      5'd1:    return "S";
      5'd2:    return "L";
      default: return "O";
    endcase
  endfunction

  assign tx_valid_o = (state_q != RSP_IDLE);
  assign tx_data_o  = (state_q == RSP_META) ? meta_byte(idx_q) :
                      (state_q == RSP_ID)   ? id_byte(idx_q)   : 8'h00;
  assign last = ((state_q == RSP_ID)   && (idx_q == IDX_W'(ID_LEN - 1))) ||
                ((state_q == RSP_META) && (idx_q == IDX_W'(META_LEN - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RSP_IDLE;
      idx_q   <= '0;
    end else if (flush_i) begin
      state_q <= RSP_IDLE;
      idx_q   <= '0;
    end else if (state_q == RSP_IDLE) begin
      idx_q <= '0;
      if (id_req_i)        state_q <= RSP_ID;
      else if (meta_req_i) state_q <= RSP_META;
    end else if (tx_ready_i) begin
      if (last) begin
        state_q <= RSP_IDLE;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/la_cmd_rx.sv
module la_cmd_rx
  import la_cmd_pkg::*;
#(
  parameter int unsigned NUM_STAGES  = 4,
  parameter int unsigned DIV_W       = 24,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned FLAG_W      = 16,
  parameter logic [31:0] MEM_BYTES   = 32'h0000_6000,
  parameter logic [31:0] MAX_RATE_HZ = 32'd100_000_000,
  parameter logic [7:0]  NUM_PROBES  = 8'd32,
  parameter logic [7:0]  PROTO_VER   = 8'd2,
  localparam int unsigned TRIG_W     = NUM_STAGES * 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic              done_i,
  output logic              run_o,
  output logic              abort_o,
  output logic              armed_o,
  output logic [DIV_W-1:0]  divider_o,
  output logic [CNT_W-1:0]  read_cnt_o,
  output logic [CNT_W-1:0]  delay_cnt_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [TRIG_W-1:0] trig_mask_o,
  output logic [TRIG_W-1:0] trig_value_o,
  output logic [TRIG_W-1:0] trig_cfg_o,
  output logic [TRIG_W-1:0] trig_edge_o
);
  logic        cmd_vld;
  logic [7:0]  cmd_op;
  logic [31:0] cmd_arg;
  logic        id_req, meta_req, flush;

  la_cmd_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .cmd_vld_o  (cmd_vld),
    .cmd_op_o   (cmd_op),
    .cmd_arg_o  (cmd_arg)
  );

  la_cmd_regs #(
    .NUM_STAGES (NUM_STAGES),
    .DIV_W      (DIV_W),
    .CNT_W      (CNT_W),
    .FLAG_W     (FLAG_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_vld_i    (cmd_vld),
    .cmd_op_i     (cmd_op),
    .cmd_arg_i    (cmd_arg),
    .done_i       (done_i),
    .id_req_o     (id_req),
    .meta_req_o   (meta_req),
    .flush_o      (flush),
    .run_o        (run_o),
    .abort_o      (abort_o),
    .armed_o      (armed_o),
    .divider_o    (divider_o),
    .read_cnt_o   (read_cnt_o),
    .delay_cnt_o  (delay_cnt_o),
    .flags_o      (flags_o),
    .trig_mask_o  (trig_mask_o),
    .trig_value_o (trig_value_o),
    .trig_cfg_o   (trig_cfg_o),
    .trig_edge_o  (trig_edge_o)
  );

  la_cmd_resp #(
    .MEM_BYTES   (MEM_BYTES),
    .MAX_RATE_HZ (MAX_RATE_HZ),
    .NUM_PROBES  (NUM_PROBES),
    .PROTO_VER   (PROTO_VER)
  ) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_req_i   (id_req),
    .meta_req_i (meta_req),
    .flush_i    (flush),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i)
  );
endmodule

// File: rtl/la_cmd_rx_chk.sv
module la_cmd_rx_chk #(
  parameter int unsigned DIV_W  = 24,
  parameter int unsigned FLAG_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic [7:0]        tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              run_o,
  input logic              abort_o,
  input logic              armed_o,
  input logic [DIV_W-1:0]  divider_o,
  input logic [FLAG_W-1:0] flags_o
);
  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({run_o, abort_o}));

  assert_arm_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> run_o);

  assert_abort_disarm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !armed_o);

  assert_tx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> ((tx_valid_o && $stable(tx_data_o)) || abort_o));

  assert_cfg_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(divider_o) || !$stable(flags_o)) |-> $past(rx_valid_i, 2));

  assert_tx_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(rx_valid_i, 2));
endmodule

bind la_cmd_rx la_cmd_rx_chk #(
  .DIV_W  (DIV_W),
  .FLAG_W (FLAG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .run_o      (run_o),
  .abort_o    (abort_o),
  .armed_o    (armed_o),
  .divider_o  (divider_o),
  .flags_o    (flags_o)
);

// File: tb/la_cmd_rx_tb.sv
module la_cmd_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int TW = NS * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic done = 1'b0;
  logic run, abort_s, armed;
  logic [23:0] divider;
  logic [31:0] read_cnt, delay_cnt;
  logic [15:0] flags;
  logic [TW-1:0] tmask, tval, tcfg, tedge;

  always #(CLK_PERIOD/2) clk = ~clk;

  la_cmd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .done_i(done), .run_o(run), .abort_o(abort_s), .armed_o(armed),
    .divider_o(divider), .read_cnt_o(read_cnt), .delay_cnt_o(delay_cnt),
    .flags_o(flags), .trig_mask_o(tmask), .trig_value_o(tval),
    .trig_cfg_o(tcfg), .trig_edge_o(tedge)
  );

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  int got_n = 0;
  logic [7:0] got [0:63];
  int run_cnt = 0;
  int abort_cnt = 0;
  bit gaps = 1'b0;

  logic [23:0] m_div;
  logic [31:0] m_rc, m_dc;
  logic [15:0] m_fl;
  logic [TW-1:0] m_tm, m_tv, m_tc, m_te;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reply collector and strobe counters
  initial begin
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0: tx_ready = 1'b0;
        1: tx_ready = 1'b1;
        default: tx_ready = 1'($urandom % 2);
      endcase
      if (tx_valid && tx_ready && got_n < 64) begin
        got[got_n] = tx_data;
        got_n++;
      end
      if (run) run_cnt++;
      if (abort_s) abort_cnt++;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    rx_data = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    if (gaps) repeat ($urandom % 3) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_meta(input int i);
    logic [7:0] t [0:21];
    t = '{8'h01, "L", "A", "C", "M", "D", 8'h00,
          8'h21, 8'h00, 8'h00, 8'h60, 8'h00,
          8'h23, 8'h05, 8'hF5, 8'hE1, 8'h00,
          8'h40, 8'd32, 8'h41, 8'd2, 8'h00};
    return t[i];
  endfunction

  // bench model of register effects
  task automatic model_long(input logic [7:0] op, input logic [31:0] a);
    int s;
    if (op == 8'h80) m_div = a[23:0];
    else if (op == 8'h81) m_rc = a;
    else if (op == 8'h82) m_dc = a;
    else if (op == 8'h83) m_fl = a[15:0];
    else if (op[7:6] == 2'b11) begin
      s = int'(op[5:2]);
      if (s < NS) begin
        case (op[1:0])
          2'd0: m_tm[s*32 +: 32] = a;
          2'd1: m_tv[s*32 +: 32] = a;
          2'd2: m_tc[s*32 +: 32] = a;
          default: m_te[s*32 +: 32] = a;
        endcase
      end
    end
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] a);
    send_byte(op);
    for (int i = 0; i < 4; i++) send_byte(a[i*8 +: 8]);
    model_long(op, a);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_model(input string tag);
    check(divider == m_div, {tag, " divider"}, divider, m_div);
    check(read_cnt == m_rc, {tag, " read_cnt"}, read_cnt, m_rc);
    check(delay_cnt == m_dc, {tag, " delay_cnt"}, delay_cnt, m_dc);
    check(flags == m_fl, {tag, " flags"}, flags, m_fl);
    check(tmask == m_tm, {tag, " trig_mask"}, tmask, m_tm);
    check(tval == m_tv, {tag, " trig_value"}, tval, m_tv);
    check(tcfg == m_tc, {tag, " trig_cfg"}, tcfg, m_tc);
    check(tedge == m_te, {tag, " trig_edge"}, tedge, m_te);
  endtask

  task automatic wait_reply(input int n);
    for (int i = 0; i < 400 && got_n < n; i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rc0, ab0;
    logic [31:0] v;
    logic [7:0] op;
    void'($urandom(32'd4242));
    {m_div, m_rc, m_dc, m_fl} = '0;
    {m_tm, m_tv, m_tc, m_te} = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_model("R1");
    check(!tx_valid && !run && !abort_s && !armed, "R1 strobes", {tx_valid, run, abort_s, armed}, 0);

    // R3 counts, LSB first
    gaps = 1'b1;
    for (int i = 0; i < 6; i++) begin
      send_long(8'h81, $urandom);
      send_long(8'h82, $urandom);
    end
    settle();
    check(read_cnt == m_rc, "R3 read_cnt", read_cnt, m_rc);
    check(delay_cnt == m_dc, "R3 delay_cnt", delay_cnt, m_dc);

    // R4 truncation
    for (int i = 0; i < 4; i++) begin
      v = $urandom | 32'hFF00_0000;
      send_long(8'h80, v);
      settle();
      check(divider == v[23:0], "R4 divider", divider, v[23:0]);
      v = $urandom | 32'hFFFF_0000;
      send_long(8'h83, v);
      settle();
      check(flags == v[15:0], "R4 flags", flags, v[15:0]);
    end

    // R5 trigger addressing
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++) send_long(8'hC0 + 8'(s * 4 + k), $urandom);
    settle();
    check_model("R5");
    send_long(8'hD0, $urandom);
    send_long(8'hF7, $urandom);
    send_long(8'hFF, $urandom);
    settle();
    check_model("R5 stage out of range");

    // R2 undefined opcodes
    gaps = 1'b0;
    rdy_mode = 1;
    got_n = 0;
    rc0 = run_cnt;
    ab0 = abort_cnt;
    send_byte(8'h03);
    send_byte(8'h11);
    send_byte(8'h7F);
    send_long(8'h84, $urandom);
    send_long(8'hA5, $urandom);
    send_long(8'hBF, $urandom);
    repeat (8) @(negedge clk);
    check_model("R2 undefined");
    check(got_n == 0, "R2 no reply", got_n, 0);
    check(run_cnt == rc0 && abort_cnt == ab0, "R2 no strobe", {run_cnt, abort_cnt}, {rc0, ab0});
    v = $urandom;
    send_long(8'h80, v);
    settle();
    check(divider == v[23:0], "R2 alignment after undefined", divider, v[23:0]);

    // R12 latency
    v = $urandom;
    send_byte(8'h83);
    for (int i = 0; i < 4; i++) send_byte(v[i*8 +: 8]);
    check(flags == m_fl, "R12 not yet", flags, m_fl);
    @(negedge clk);
    check(flags == v[15:0], "R12 after two edges", flags, v[15:0]);
    m_fl = v[15:0];

    // R6 identify
    rdy_mode = 2;
    got_n = 0;
    send_byte(8'h02);
    wait_reply(4);
    check(got_n == 4, "R6 length", got_n, 4);
    check({got[0], got[1], got[2], got[3]} == 32'h31534C4F, "R6 bytes",
          {got[0], got[1], got[2], got[3]}, 32'h31534C4F);

    // R7 metadata
    got_n = 0;
    send_byte(8'h04);
    wait_reply(22);
    check(got_n == 22, "R7 length", got_n, 22);
    for (int i = 0; i < 22; i++)
      if (got[i] != exp_meta(i)) check(1'b0, "R7 byte", got[i], exp_meta(i));
    check(got[21] == 8'h00, "R7 terminator", got[21], 0);

    // R11 query while busy
    rdy_mode = 0;
    got_n = 0;
    send_byte(8'h02);
    send_byte(8'h04);
    rdy_mode = 2;
    wait_reply(4);
    check(got_n == 4, "R11 length", got_n, 4);
    check(got[3] == 8'h4F, "R11 last byte", got[3], 8'h4F);

    // R9 abort reply and capture
    rdy_mode = 0;
    got_n = 0;
    send_byte(8'h04);
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b1, "R9 reply pending", tx_valid, 1);
    ab0 = abort_cnt;
    send_byte(8'h00);
    repeat (2) @(negedge clk);
    check(tx_valid == 1'b0, "R9 reply dropped", tx_valid, 0);
    check(abort_cnt == ab0 + 1, "R9 abort pulse", abort_cnt, ab0 + 1);
    rdy_mode = 1;
    repeat (10) @(negedge clk);
    check(got_n == 0, "R9 no bytes", got_n, 0);

    // R8 run / done / reset
    rc0 = run_cnt;
    send_byte(8'h01);
    repeat (2) @(negedge clk);
    check(run_cnt == rc0 + 1, "R8 run pulse", run_cnt, rc0 + 1);
    check(armed == 1'b1, "R8 armed", armed, 1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    check(armed == 1'b0, "R8 done clears", armed, 0);
    send_byte(8'h01);
    repeat (2) @(negedge clk);
    check(armed == 1'b1, "R8 rearmed", armed, 1);
    send_byte(8'h00);
    repeat (2) @(negedge clk);
    check(armed == 1'b0, "R9 reset disarms", armed, 0);

    // R10 resync from every position
    for (int k = 0; k <= 4; k++) begin
      ab0 = abort_cnt;
      if (k > 0) begin
        send_byte(8'h80);
        for (int j = 1; j < k; j++) send_byte(8'($urandom));
      end
      repeat (5) send_byte(8'h00);
      repeat (3) @(negedge clk);
      check(abort_cnt == ab0 + ((k == 0) ? 5 : k), "R10 resets issued", abort_cnt, ab0 + ((k == 0) ? 5 : k));
      v = $urandom;
      send_long(8'h80, v);
      settle();
      check(divider == v[23:0], "R10 realigned", divider, v[23:0]);
    end

    // random mix against model (R3 R4 R5)
    gaps = 1'b1;
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 3)
        0: op = 8'h80 + 8'($urandom % 4);
        1: op = 8'hC0 + 8'($urandom % 64);
        default: op = 8'h84 + 8'($urandom % 60);
      endcase
      send_long(op, $urandom);
    end
    settle();
    check_model("R5 random mix");

    finish_run();
  end
endmodule